// File: doc/BRIEF.md
# Regulator Rail Enable and Switching-Mode Controller

This block drives the on/off control and the PWM/PFM choice of three switching regulator rails. Its inputs are the current power-state code, a sequencing-in-progress flag, a strobe marking the expiry of the last power-up slot, per-rail enable bits for the active and standby states, a mode pin with a validity qualifier, a mode override bit written over I2C, a per-rail voltage-transition-busy flag, and a per-rail bandwidth-select value. For each rail it produces a registered enable, a registered forced-PWM signal and a registered bandwidth setting. The analog converter, the sequencer timer and the register file that feed it are outside the block.

Rail enables follow the power state. PFM permission is held by a small state machine with three states: `GATE_LOCKED`, `GATE_ARMING` and `GATE_RELEASED`. It moves through the transitions *lock* (any state, to `GATE_LOCKED`, when the code is neither ACTIVE nor STBY), *arm* (`GATE_LOCKED` to `GATE_ARMING` when the code is ACTIVE), *release* (`GATE_ARMING` to `GATE_RELEASED` when the code is ACTIVE, no sequence is running and the last-slot strobe is high), and *rearm* (`GATE_RELEASED` to `GATE_ARMING` when ACTIVE is entered again from another code or a sequence starts). Until the gate is released every rail runs in forced PWM. After release, the choice comes from the mode requests. A rail with a voltage transition in progress still runs in forced PWM.

Top module: `rail_ctrl`

## Requirements
- R1: With power-state code 2 (ACTIVE), rail i is enabled exactly when act_en[i] is 1. Codes: 0 OFF, 1 INITIALIZE, 2 ACTIVE, 3 STBY, 4 SLEEP, with 5 to 7 treated as OFF.
- R2: With code 3 (STBY), rail i is enabled exactly when stby_en[i] is 1.
- R3: With code 1 (INITIALIZE) or 4 (SLEEP), every rail_en bit is 0, whatever the enable bits are.
- R4: During reset, and with code 0 or 5 to 7, rail_en is all 0 and rail_fpwm is all 1.
- R5: Every rail is forced to PWM while the code is INITIALIZE, and from the cycle ACTIVE is entered from any other code until the gate is released.
- R6: PFM is released only when the code is ACTIVE, seq_busy is 0 and last_slot_done is 1, all in the same cycle. A strobe while seq_busy is 1 is ignored. A release survives a move to STBY. It is withdrawn when seq_busy rises or when ACTIVE is entered again.
- R7: xfer_busy[i] = 1 forces rail i, and only rail i, to PWM.
- R8: Once PFM is released, a rail with no transition in progress is in forced PWM exactly when i2c_pwm_req is 1, or when mode_pin is 1 and mode_pin_valid is 1. When mode_pin_valid is 0, mode_pin has no effect.
- R9: rail_bw for rail i takes bw_sel_in for rail i only on a clock where rail i is disabled. While the rail is enabled, its rail_bw holds.
- R10: All outputs are registered and reflect the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_state | input | 3 | Power-state code |
| seq_busy | input | 1 | A power sequence is in progress |
| last_slot_done | input | 1 | Strobe: last power-up slot has expired |
| act_en | input | NUM_RAILS | Per-rail enable for ACTIVE |
| stby_en | input | NUM_RAILS | Per-rail enable for STBY |
| mode_pin | input | 1 | Mode pin; 1 requests forced PWM |
| mode_pin_valid | input | 1 | Mode pin is configured as a mode source |
| i2c_pwm_req | input | 1 | Software mode bit; 1 requests forced PWM |
| xfer_busy | input | NUM_RAILS | Per-rail voltage transition in progress |
| bw_sel_in | input | NUM_RAILS*BW_W | Requested bandwidth setting per rail |
| rail_en | output | NUM_RAILS | Registered rail enables |
| rail_fpwm | output | NUM_RAILS | Registered forced-PWM per rail |
| rail_bw | output | NUM_RAILS*BW_W | Latched bandwidth setting per rail |

## Verification
The release of PFM and a voltage transition on one rail can fall in the same cycle. The bench drives the last-slot strobe together with xfer_busy on the middle rail and expects, one clock later, PFM on the outer rails and forced PWM on the middle rail. A second overlap is a bandwidth change on the same clock as a rail enable. The value is expected to be latched, because the rail was still disabled at that edge, and to hold once the rail is enabled. A scoreboard judges both from a model built only on the requirements.

// File: rtl/rail_mode_pkg.sv
package rail_mode_pkg;

    typedef enum logic [2:0] {
        PS_OFF    = 3'd0,
        PS_INIT   = 3'd1,
        PS_ACTIVE = 3'd2,
        PS_STBY   = 3'd3,
        PS_SLEEP  = 3'd4
    } pwr_state_e;

    typedef enum logic [1:0] {
        GATE_LOCKED   = 2'd0,
        GATE_ARMING   = 2'd1,
        GATE_RELEASED = 2'd2
    } pfm_gate_e;

    // Unused codes collapse to OFF so that rails stay safely disabled.
    function automatic pwr_state_e decode_state(input logic [2:0] code);
        pwr_state_e s;
        case (code)
            3'd1:    s = PS_INIT;
            3'd2:    s = PS_ACTIVE;
            3'd3:    s = PS_STBY;
            3'd4:    s = PS_SLEEP;
            default: s = PS_OFF;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pfm_gate.sv
module pfm_gate
    import rail_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pwr_state_e ps,
    input  logic       seq_busy,
    input  logic       slot_done,
    output logic       pfm_ok_nxt
);

    pfm_gate_e  gate_q, gate_d;
    pwr_state_e prev_q;
    logic       runs_rails;
    logic       enters_active;

    assign runs_rails    = (ps == PS_ACTIVE) || (ps == PS_STBY);
    assign enters_active = (ps == PS_ACTIVE) && (prev_q != PS_ACTIVE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= GATE_LOCKED;
            prev_q <= PS_OFF;
        end else begin
            gate_q <= gate_d;
            prev_q <= ps;
        end
    end

    // next state
    always_comb begin
        gate_d = gate_q;
        if (!runs_rails) begin
            gate_d = GATE_LOCKED;
        end else begin
            unique case (gate_q)
                GATE_LOCKED:
                    if (ps == PS_ACTIVE) gate_d = GATE_ARMING;
                GATE_ARMING:
                    if ((ps == PS_ACTIVE) && slot_done && !seq_busy)
                        gate_d = GATE_RELEASED;
                GATE_RELEASED:
                    if (enters_active || seq_busy) gate_d = GATE_ARMING;
                default:
                    gate_d = GATE_LOCKED;
            endcase
        end
    end

    // outputs: permission follows the next state so rail outputs see one register
    always_comb begin
        pfm_ok_nxt = (gate_d == GATE_RELEASED);
    end

    // R5
    always @(posedge clk) begin
        lock_outside_chk: assert property (disable iff (!rst_n)
            !((ps == PS_ACTIVE) || (ps == PS_STBY)) |=> (gate_q == GATE_LOCKED));
    end

    // R6
    always @(posedge clk) begin
        release_cause_chk: assert property (disable iff (!rst_n)
            $rose(gate_q == GATE_RELEASED) |->
                ($past(ps) == PS_ACTIVE) && $past(slot_done) && !$past(seq_busy));
    end

endmodule

// File: rtl/mode_request.sv
module mode_request (
    input  logic mode_pin,
    input  logic mode_pin_valid,
    input  logic i2c_pwm_req,
    output logic pwm_req
);

    logic pin_req;

    always_comb begin
        pin_req = mode_pin_valid & mode_pin;
        pwm_req = pin_req | i2c_pwm_req;
    end

endmodule

// File: rtl/rail_channel.sv
module rail_channel
    import rail_mode_pkg::*;
#(
    parameter int BW_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pwr_state_e      ps,
    input  logic            act_en,
    input  logic            stby_en,
    input  logic            pfm_ok_nxt,
    input  logic            pwm_req,
    input  logic            xfer_busy,
    input  logic [BW_W-1:0] bw_in,
    output logic            en_q,
    output logic            fpwm_q,
    output logic [BW_W-1:0] bw_q
);

    logic en_d;
    logic fpwm_d;

    always_comb begin
        unique case (ps)
            PS_ACTIVE: en_d = act_en;
            PS_STBY:   en_d = stby_en;
            default:   en_d = 1'b0;
        endcase
        fpwm_d = !pfm_ok_nxt || xfer_busy || pwm_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            fpwm_q <= 1'b1;
            bw_q   <= '0;
        end else begin
            en_q   <= en_d;
            fpwm_q <= fpwm_d;
            if (!en_q) bw_q <= bw_in;
        end
    end

    // R3
    always @(posedge clk) begin
        idle_off_chk: assert property (disable iff (!rst_n)
            ((ps == PS_INIT) || (ps == PS_SLEEP)) |=> !en_q);
    end

    // R7
    always @(posedge clk) begin
        busy_pwm_chk: assert property (disable iff (!rst_n)
            xfer_busy |=> fpwm_q);
    end

    // R9
    always @(posedge clk) begin
        bw_hold_chk: assert property (disable iff (!rst_n)
            $past(en_q) |-> $stable(bw_q));
    end

endmodule

// File: rtl/rail_ctrl.sv
module rail_ctrl
    import rail_mode_pkg::*;
#(
    parameter int NUM_RAILS = 3,
    parameter int BW_W      = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                pwr_state,
    input  logic                      seq_busy,
    input  logic                      last_slot_done,
    input  logic [NUM_RAILS-1:0]      act_en,
    input  logic [NUM_RAILS-1:0]      stby_en,
    input  logic                      mode_pin,
    input  logic                      mode_pin_valid,
    input  logic                      i2c_pwm_req,
    input  logic [NUM_RAILS-1:0]      xfer_busy,
    input  logic [NUM_RAILS*BW_W-1:0] bw_sel_in,
    output logic [NUM_RAILS-1:0]      rail_en,
    output logic [NUM_RAILS-1:0]      rail_fpwm,
    output logic [NUM_RAILS*BW_W-1:0] rail_bw
);

    localparam int BW_TOTAL = NUM_RAILS * BW_W;

    pwr_state_e ps;
    logic       pfm_ok_nxt;
    logic       pwm_req;

    assign ps = decode_state(pwr_state);

    pfm_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ps         (ps),
        .seq_busy   (seq_busy),
        .slot_done  (last_slot_done),
        .pfm_ok_nxt (pfm_ok_nxt)
    );

    mode_request u_req (
        .mode_pin       (mode_pin),
        .mode_pin_valid (mode_pin_valid),
        .i2c_pwm_req    (i2c_pwm_req),
        .pwm_req        (pwm_req)
    );

    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        rail_channel #(.BW_W(BW_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ps         (ps),
            .act_en     (act_en[r]),
            .stby_en    (stby_en[r]),
            .pfm_ok_nxt (pfm_ok_nxt),
            .pwm_req    (pwm_req),
            .xfer_busy  (xfer_busy[r]),
            .bw_in      (bw_sel_in[r*BW_W +: BW_W]),
            .en_q       (rail_en[r]),
            .fpwm_q     (rail_fpwm[r]),
            .bw_q       (rail_bw[r*BW_W +: BW_W])
        );
    end

    // R4
    always @(posedge clk) begin
        off_safe_chk: assert property (disable iff (!rst_n)
            (ps == PS_OFF) |=> ((rail_en == '0) && (&rail_fpwm)));
    end

    // R1
    always @(posedge clk) begin
        active_follow_chk: assert property (disable iff (!rst_n)
            (ps == PS_ACTIVE) |=> (rail_en == $past(act_en)));
    end

    initial begin
        bw_size_chk: assert (BW_TOTAL == $bits(rail_bw));
    end

endmodule

// File: tb/tb_rail_ctrl.sv
module tb_rail_ctrl;

    localparam int N = 3;

    typedef struct {
        logic [N-1:0] en;
        logic [N-1:0] fpwm;
        logic [N-1:0] bw;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   pwr_state = 3'd0;
    logic         seq_busy = 1'b0, last_slot_done = 1'b0;
    logic [N-1:0] act_en = '0, stby_en = '0, xfer_busy = '0, bw_sel_in = '0;
    logic         mode_pin = 1'b0, mode_pin_valid = 1'b0, i2c_pwm_req = 1'b0;
    logic [N-1:0] rail_en, rail_fpwm, rail_bw;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb[$];

    // bench model state (0 locked, 1 arming, 2 released)
    int           m_gate = 0;
    logic [2:0]   m_prev = 3'd0;
    logic [N-1:0] m_en = '0, m_fpwm = '1, m_bw = '0;

    always #5 clk = ~clk;

    rail_ctrl #(.NUM_RAILS(N), .BW_W(1)) dut (
        .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .seq_busy(seq_busy),
        .last_slot_done(last_slot_done), .act_en(act_en), .stby_en(stby_en),
        .mode_pin(mode_pin), .mode_pin_valid(mode_pin_valid), .i2c_pwm_req(i2c_pwm_req),
        .xfer_busy(xfer_busy), .bw_sel_in(bw_sel_in),
        .rail_en(rail_en), .rail_fpwm(rail_fpwm), .rail_bw(rail_bw)
    );

    task automatic cmp(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic [2:0] st, input logic sq, input logic slot,
                        input logic [N-1:0] ae, input logic [N-1:0] se,
                        input logic pin, input logic pinv, input logic i2c,
                        input logic [N-1:0] busy, input logic [N-1:0] bw, input string tag);
        int g;
        bit run, req;
        exp_t e;
        @(negedge clk);
        pwr_state = st; seq_busy = sq; last_slot_done = slot; act_en = ae; stby_en = se;
        mode_pin = pin; mode_pin_valid = pinv; i2c_pwm_req = i2c; xfer_busy = busy; bw_sel_in = bw;
        run = (st == 3'd2) || (st == 3'd3);
        g = m_gate;
        if (!run) g = 0;
        else if (m_gate == 0) g = (st == 3'd2) ? 1 : 0;
        else if (m_gate == 1) g = ((st == 3'd2) && slot && !sq) ? 2 : 1;
        else g = (((st == 3'd2) && (m_prev != 3'd2)) || sq) ? 1 : 2;
        req = i2c || (pin && pinv);
        for (int i = 0; i < N; i++) begin
            e.bw[i]   = m_en[i] ? m_bw[i] : bw[i];
            e.en[i]   = (st == 3'd2) ? ae[i] : (st == 3'd3) ? se[i] : 1'b0;
            e.fpwm[i] = (g != 2) || busy[i] || req;
        end
        e.tag = tag;
        m_gate = g; m_prev = st; m_en = e.en; m_fpwm = e.fpwm; m_bw = e.bw;
        sb.push_back(e);
    endtask

    // monitor: R10, each queued item is compared one clock after its stimulus
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                cmp(e.tag, "rail_en",   rail_en,   e.en);
                cmp(e.tag, "rail_fpwm", rail_fpwm, e.fpwm);
                cmp(e.tag, "rail_bw",   rail_bw,   e.bw);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #22;
        cmp("R4", "reset rail_en", rail_en, '0);
        cmp("R4", "reset rail_fpwm", rail_fpwm, '1);
        @(negedge clk); rst_n = 1'b1;
        //   st    sq slot ae      se      pin v  i2c busy    bw
        step(3'd0, 0, 0, 3'b111, 3'b111, 0, 1, 0, 3'b000, 3'b000, "R4 off");
        step(3'd1, 0, 1, 3'b111, 3'b111, 0, 1, 0, 3'b000, 3'b000, "R3 R5 init");
        step(3'd2, 1, 0, 3'b101, 3'b000, 0, 1, 0, 3'b000, 3'b000, "R1 R5 enter active");
        step(3'd2, 1, 1, 3'b101, 3'b000, 0, 1, 0, 3'b000, 3'b000, "R6 strobe during seq");
        step(3'd2, 0, 0, 3'b101, 3'b000, 0, 1, 0, 3'b000, 3'b000, "R6 no strobe");
        step(3'd2, 0, 1, 3'b101, 3'b000, 0, 1, 0, 3'b010, 3'b000, "R6 R7 release with busy");
        step(3'd2, 0, 0, 3'b101, 3'b000, 0, 1, 0, 3'b000, 3'b000, "R8 pfm");
        step(3'd2, 0, 0, 3'b101, 3'b000, 1, 1, 0, 3'b000, 3'b000, "R8 pin pwm");
        step(3'd2, 0, 0, 3'b101, 3'b000, 1, 0, 0, 3'b000, 3'b000, "R8 pin ignored");
        step(3'd2, 0, 0, 3'b101, 3'b000, 0, 0, 1, 3'b000, 3'b000, "R8 i2c pwm");
        step(3'd3, 0, 0, 3'b101, 3'b011, 0, 0, 0, 3'b000, 3'b111, "R2 R9 stby");
        step(3'd2, 0, 0, 3'b101, 3'b011, 0, 0, 0, 3'b000, 3'b000, "R5 reenter active");
        step(3'd2, 0, 1, 3'b111, 3'b011, 0, 0, 0, 3'b000, 3'b111, "R9 bw on enable edge");
        step(3'd2, 0, 0, 3'b111, 3'b011, 0, 0, 0, 3'b000, 3'b000, "R9 bw held");
        step(3'd2, 1, 0, 3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b000, "R6 seq relocks");
        step(3'd4, 0, 0, 3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b101, "R3 sleep");
        step(3'd7, 0, 0, 3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b000, "R4 unused code");
        step(3'd0, 0, 0, 3'b000, 3'b000, 0, 0, 0, 3'b000, 3'b000, "R10 settle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule